// File: doc/BRIEF.md
# Subroutine-Call Bus Sequencer

This block carries out the bus traffic of a three-byte absolute subroutine call on an 8-bit processor with a 16-bit address space. A start pulse hands it the address of the opcode and the current stack pointer. It then drives a byte-wide memory port for six bus cycles, with exactly one access in each. It fetches the opcode and reads the low byte of the target. It spends one internal stack cycle, pushes the return address high byte first, and reads the high byte of the target last.

The push happens between the two operand reads. A call whose operand bytes sit inside the stack page therefore picks up the bytes it has just pushed as its target high byte. When the last read completes, the block pulses `done` and presents the new program counter and the stack pointer, which has moved down by two. The memory port reads asynchronously: read data belongs to the address of the same cycle. A write takes effect at the clock edge that closes its cycle.

Top module: `call_sequencer`

## Requirements
- R1: A synchronous reset makes the sequencer idle, with `done` and `mem_we` low. A start pulse in the first cycle after reset is accepted.
- R2: In the cycle after an accepted start, bus cycle 1 reads the opcode address with no write. Bus cycle 2 reads the opcode address plus one, which is the target low byte.
- R3: Bus cycle 3 places 0x0100 + SP on the address bus and does not write.
- R4: The return address is the opcode address plus two. Bus cycle 4 writes its upper byte to 0x0100 + SP, and bus cycle 5 writes its lower byte to 0x0100 + SP − 1.
- R5: Bus cycle 6 reads the opcode address plus two, after both writes. If that address is one of the two slots just written, the value written there becomes the target high byte.
- R6: `done` is high for exactly one cycle, the cycle after bus cycle 6. In that cycle `new_pc` equals high byte × 256 + low byte, and `new_pc` holds until the next completion.
- R7: Each push decrements SP modulo 256, so `sp_out` is SP − 2 mod 256. With SP = 0x00 the writes go to 0x0100 and then 0x01FF.
- R8: A start pulse that arrives while a call is in progress is ignored. The bus trace and the result of the running call are unchanged.
- R9: A reset in the middle of a call aborts it. No further write occurs and `done` does not rise.
- R10: Operand and return addresses wrap at 16 bits. With opcode 0xFFFE the low byte comes from 0xFFFF, the high byte from 0x0000, and the return address is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a call; taken only when idle |
| opc_addr | input | 16 | Address of the call opcode, sampled with start |
| sp_in | input | 8 | Stack pointer, sampled with start |
| mem_addr | output | 16 | Memory address of the current bus cycle |
| mem_rdata | input | 8 | Read data for `mem_addr` in the same cycle |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable; the write lands at the closing edge |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 16 | Target address assembled from the two operand bytes |
| sp_out | output | 8 | Stack pointer after the two pushes |

## Verification
The first calls use plain addresses well away from the stack page, with different stack pointers. Each of the six bus cycles is compared against the expected address, write enable and data. This separates a correct cycle order from one that reads the high byte before pushing, or that pushes the bytes in the wrong order.

Two overlap cases place the high-byte operand exactly on the slot written first and on the slot written second. Only a read that follows both pushes returns the pushed byte in each case. A wrap case at 0xFFFE with SP = 0x00 exposes missing 16-bit and 8-bit modular arithmetic. A start pulse injected mid-call and a reset injected mid-call show that busy starts are ignored and that an abort issues no stray write.

// File: rtl/call_seq_pkg.sv
package call_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_FETCH = 3'd1,
        PH_LO    = 3'd2,
        PH_SPI   = 3'd3,
        PH_PUSHH = 3'd4,
        PH_PUSHL = 3'd5,
        PH_HI    = 3'd6
    } phase_t;

    localparam int CS_ADDR_W = 16;
    localparam int CS_DATA_W = 8;

endpackage

// File: rtl/call_seq_fsm.sv
module call_seq_fsm
    import call_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output logic   accept,
    output phase_t phase
);

    typedef struct packed {
        phase_t ph;
    } fsm_t;

    fsm_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        accept = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    accept   = 1'b1;
                    st_d.ph  = PH_FETCH;
                end
            end
            PH_FETCH: st_d.ph = PH_LO;
            PH_LO:    st_d.ph = PH_SPI;
            PH_SPI:   st_d.ph = PH_PUSHH;
            PH_PUSHH: st_d.ph = PH_PUSHL;
            PH_PUSHL: st_d.ph = PH_HI;
            PH_HI:    st_d.ph = PH_IDLE;
            default:  st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{ph: PH_IDLE};
        else     st_q <= st_d;
    end

    assign phase = st_q.ph;

    // R1: reset always lands in idle
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> phase == PH_IDLE);

    // R8: a busy sequencer never restarts from a start pulse
    assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && phase != PH_HI && start) |=> phase != PH_FETCH);

endmodule

// File: rtl/call_seq_stack.sv
module call_seq_stack #(
    parameter int SP_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [SP_W-1:0] load_val,
    input  logic            push,
    output logic [SP_W-1:0] sp
);

    typedef struct packed {
        logic [SP_W-1:0] sp;
    } stk_t;

    stk_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (load)      st_d.sp = load_val;
        else if (push) st_d.sp = st_q.sp - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sp = st_q.sp;

    // R7: each push moves the pointer down by one, modulo the width
    assert_sp_step_R7: assert property (@(posedge clk) disable iff (rst)
        (push && !load) |=> sp == $past(sp) - 1'b1);

endmodule

// File: rtl/call_seq_bus.sv
module call_seq_bus
    import call_seq_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 8,
    parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 'h01
) (
    input  phase_t             phase,
    input  logic [ADDR_W-1:0]  opc,
    input  logic [DATA_W-1:0]  sp,
    output logic [ADDR_W-1:0]  addr,
    output logic               we,
    output logic [DATA_W-1:0]  wdata
);

    logic [ADDR_W-1:0] ret_addr;
    logic [ADDR_W-1:0] stack_addr;

    assign ret_addr   = opc + ADDR_W'(2);
    assign stack_addr = {STACK_PAGE, sp};

    always_comb begin
        addr  = '0;
        we    = 1'b0;
        wdata = '0;
        unique case (phase)
            PH_FETCH: addr = opc;
            PH_LO:    addr = opc + ADDR_W'(1);
            PH_SPI:   addr = stack_addr;
            PH_PUSHH: begin
                addr  = stack_addr;
                we    = 1'b1;
                wdata = ret_addr[ADDR_W-1:ADDR_W-DATA_W];
            end
            PH_PUSHL: begin
                addr  = stack_addr;
                we    = 1'b1;
                wdata = ret_addr[DATA_W-1:0];
            end
            PH_HI:    addr = ret_addr;
            default:  addr = '0;
        endcase
    end

endmodule

// File: rtl/call_sequencer.sv
module call_sequencer
    import call_seq_pkg::*;
#(
    parameter int ADDR_W = CS_ADDR_W,
    parameter int DATA_W = CS_DATA_W,
    parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 'h01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] opc_addr,
    input  logic [DATA_W-1:0] sp_in,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              done,
    output logic [ADDR_W-1:0] new_pc,
    output logic [DATA_W-1:0] sp_out
);

    localparam int PAGE_W = ADDR_W - DATA_W;

    typedef struct packed {
        logic [ADDR_W-1:0] opc;
        logic [DATA_W-1:0] lo;
        logic [ADDR_W-1:0] pc;
        logic              done;
    } core_t;

    core_t  cr_q, cr_d;
    phase_t phase;
    logic   accept;
    logic   push;

    call_seq_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .accept (accept),
        .phase  (phase)
    );

    assign push = (phase == PH_PUSHH) || (phase == PH_PUSHL);

    call_seq_stack #(.SP_W(DATA_W)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (sp_in),
        .push     (push),
        .sp       (sp_out)
    );

    call_seq_bus #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .STACK_PAGE (STACK_PAGE)
    ) u_bus (
        .phase (phase),
        .opc   (cr_q.opc),
        .sp    (sp_out),
        .addr  (mem_addr),
        .we    (mem_we),
        .wdata (mem_wdata)
    );

    always_comb begin
        cr_d      = cr_q;
        cr_d.done = 1'b0;
        if (accept)           cr_d.opc = opc_addr;
        if (phase == PH_LO)   cr_d.lo  = mem_rdata;
        if (phase == PH_HI) begin
            cr_d.pc   = {mem_rdata, cr_q.lo};
            cr_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cr_q <= '0;
        else     cr_q <= cr_d;
    end

    assign done   = cr_q.done;
    assign new_pc = cr_q.pc;

    // R2: the first bus cycle after acceptance fetches the opcode, read only
    assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> (mem_addr == $past(opc_addr)) && !mem_we);

    // R4: writes only ever land in the stack page
    assert_push_page_R4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_addr[ADDR_W-1:DATA_W] == PAGE_W'(STACK_PAGE));

    // R4: writes come as one back-to-back pair
    assert_push_pair_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |=> mem_we);

    assert_push_pair_end_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |=> !mem_we);

    // R5: the high-byte read sits between the second push and done
    assert_hi_after_push_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (!$past(mem_we) && $past(mem_we, 2)));

    // R6: done lasts one cycle
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: result is stable between completions
    assert_pc_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!done && $past(!rst)) |-> $stable(new_pc));

endmodule

// File: tb/sim_call_sequencer.sv
`timescale 1ns/1ps
module sim_call_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] opc_addr = '0;
    logic [7:0]  sp_in = '0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        done;
    logic [15:0] new_pc;
    logic [7:0]  sp_out;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0] mem [0:1023];

    always #2.5 clk = ~clk;

    call_sequencer u0 (
        .clk(clk), .rst(rst), .start(start), .opc_addr(opc_addr), .sp_in(sp_in),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .done(done), .new_pc(new_pc), .sp_out(sp_out)
    );

    assign mem_rdata = mem[mem_addr[9:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;

    task automatic chk(input string req, input string what,
                       input int unsigned act, input int unsigned exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Full call with per-cycle checks; poke injects a start while busy (R8)
    task automatic run_call(input logic [15:0] opc, input logic [7:0] sp,
                            input bit poke, output logic [15:0] pc_got);
        logic [15:0] ret, hi_a, sa_h, sa_l;
        logic [7:0]  lo_e, hi_e;
        ret  = opc + 16'd2;
        hi_a = opc + 16'd2;
        sa_h = {8'h01, sp};
        sa_l = {8'h01, sp - 8'd1};
        lo_e = mem[10'(opc + 16'd1)];
        if (hi_a[9:0] == sa_h[9:0])      hi_e = ret[15:8];
        else if (hi_a[9:0] == sa_l[9:0]) hi_e = ret[7:0];
        else                             hi_e = mem[hi_a[9:0]];

        @(negedge clk); start = 1'b1; opc_addr = opc; sp_in = sp;
        @(negedge clk); start = 1'b0;
        chk("R2", "c1 addr", mem_addr, opc);
        chk("R2", "c1 we", mem_we, 0);
        if (poke) begin start = 1'b1; opc_addr = 16'h0333; sp_in = 8'h11; end
        @(negedge clk); start = 1'b0;
        chk("R2", "c2 addr", mem_addr, 16'(opc + 16'd1));
        @(negedge clk);
        chk("R3", "c3 addr", mem_addr, sa_h);
        chk("R3", "c3 we", mem_we, 0);
        @(negedge clk);
        chk("R4", "c4 addr", mem_addr, sa_h);
        chk("R4", "c4 we/data", {mem_we, mem_wdata}, {1'b1, ret[15:8]});
        @(negedge clk);
        chk("R4", "c5 addr", mem_addr, sa_l);
        chk("R4", "c5 we/data", {mem_we, mem_wdata}, {1'b1, ret[7:0]});
        @(negedge clk);
        chk("R5", "c6 addr", mem_addr, hi_a);
        chk("R5", "c6 we/done", {mem_we, done}, 0);
        @(negedge clk);
        chk("R6", "done", done, 1);
        chk("R6", "new_pc", new_pc, {hi_e, lo_e});
        chk("R7", "sp_out", sp_out, 8'(sp - 8'd2));
        pc_got = new_pc;
        @(negedge clk);
        chk("R6", "done falls", done, 0);
        chk("R6", "pc held", new_pc, {hi_e, lo_e});
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", done, 0);
        chk("R1", "we in reset", mem_we, 0);
        rst = 1'b0;
    endtask

    task automatic t_plain();
        logic [15:0] pc;
        mem[10'h241] = 8'h34; mem[10'h242] = 8'h12;
        run_call(16'h0240, 8'hFD, 0, pc);
        chk("R6", "plain target", pc, 16'h1234);
        mem[10'h2A1] = 8'hC3; mem[10'h2A2] = 8'h9E;
        run_call(16'h02A0, 8'h80, 0, pc);
        chk("R6", "plain target 2", pc, 16'h9EC3);
    endtask

    task automatic t_overlap_first();
        logic [15:0] pc;
        mem[10'h1F1] = 8'h34;
        run_call(16'h01F0, 8'hF2, 0, pc);   // hi operand at first pushed slot
        chk("R5", "overlap first slot", pc, 16'h0134);
    endtask

    task automatic t_overlap_second();
        logic [15:0] pc;
        mem[10'h1F0] = 8'h77;
        run_call(16'h01EF, 8'hF2, 0, pc);   // hi operand at second pushed slot
        chk("R5", "overlap second slot", pc, 16'hF177);
    endtask

    task automatic t_wrap();
        logic [15:0] pc;
        mem[10'h3FF] = 8'h5C; mem[10'h000] = 8'hA7;
        run_call(16'hFFFE, 8'h00, 0, pc);
        chk("R10", "wrap target", pc, 16'hA75C);
        chk("R10", "wrap ret hi", mem[10'h100], 8'h00);
        chk("R7", "sp wrap slot", mem[10'h1FF], 8'h00);
    endtask

    task automatic t_busy();
        logic [15:0] pc;
        mem[10'h261] = 8'hEF; mem[10'h262] = 8'hBE;
        run_call(16'h0260, 8'hC0, 1, pc);
        chk("R8", "busy start ignored", pc, 16'hBEEF);
        @(negedge clk);
        chk("R8", "no restart", mem_addr, 16'h0000);
    endtask

    task automatic t_abort();
        logic [15:0] pc;
        bit bad;
        mem[10'h1A0] = 8'h3C; mem[10'h19F] = 8'h3D;
        @(negedge clk); start = 1'b1; opc_addr = 16'h0280; sp_in = 8'hA0;
        @(negedge clk); start = 1'b0;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (mem_we || done) bad = 1;
        end
        chk("R9", "no write/done after abort", bad, 0);
        chk("R9", "stack untouched", {mem[10'h1A0], mem[10'h19F]}, 16'h3C3D);
        mem[10'h2C1] = 8'h01; mem[10'h2C2] = 8'h80;
        run_call(16'h02C0, 8'h50, 0, pc);
        chk("R1", "call after reset", pc, 16'h8001);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'(i) ^ 8'h5A;
        t_reset();
        t_plain();
        t_overlap_first();
        t_overlap_second();
        t_wrap();
        t_busy();
        t_abort();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule